// File: doc/BRIEF.md
# Complementary Scan Clock Output Controller

This block is the digital control core of a panel gate-scan driver. A frame start input, a row qualifier and one line clock per channel come from a timing controller that is asynchronous to the local system clock. The block resynchronises them and produces a 2-bit drive code for each high-voltage output: one start pulse output and, per channel, a true and a complementary scan clock. It also produces a charge-share enable for each channel. Level shifters and analog switches downstream turn each code into the high rail, the low rail or a floating output.

While frame start is low, each channel works as a toggle. Every rising edge of its line clock flips a stored state. Both outputs float and charge sharing is enabled while the line clock is low. While frame start is high, the line clock level drives the pair directly. A global enable from the power sequencer forces every output to the low rail and clears the stored state. Per-output override inputs let the sequencer force the low rail or a floating output on top of the logic result.

Top module: `scan_clk_ctrl`

## Requirements
- R1: Drive codes are 2'b00 floating, 2'b01 low rail and 2'b10 high rail. The code 2'b11 is never produced. While reset is asserted and after it is released, with enable low, every drive output is 2'b01 and every share enable is 0.
- R2: With enable high, frame start low and a channel's line clock low, both outputs of that channel are 2'b00 and its share enable is 1.
- R3: With enable high and frame start low, each rising edge of a line clock flips that channel's stored state. The true output then drives 2'b10 when the state is 1 and 2'b01 when it is 0, and the complementary output drives the opposite code. The share enable is 0.
- R4: With frame start low and the line clock held high, the outputs keep the codes of the stored state. A line clock edge that happens while frame start is high does not change the stored state.
- R5: With frame start high and the line clock low, the true output is 2'b01, the complementary output is 2'b10 and the share enable is 0.
- R6: With frame start high and the line clock high, the true output is 2'b10, the complementary output is 2'b01 and the share enable is 0.
- R7: With enable high and frame start low, the start pulse output is 2'b01 whatever the level of channel 0's line clock.
- R8: With frame start high, the start pulse output is 2'b10 when channel 0's line clock is low and 2'b00 when it is high.
- R9: With enable low, every output is 2'b01 and every share enable is 0, whatever the overrides are. The stored state of every channel is cleared to 0, so the first rising edge after enable returns makes the true output 2'b10.
- R10: Override code 2'b01 forces that output to 2'b01 and code 2'b10 forces it to 2'b00. Codes 2'b00 and 2'b11 leave the logic result unchanged. Overrides never change the share enables.
- R11: An input change before rising clock edge k shows on the outputs after rising edge k+SYNC_STAGES, which is the third edge with the default parameters. The outputs still show the old values after edge k+SYNC_STAGES-1.
- R12: The channels are independent: a line clock change on one channel leaves the codes of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable from the power sequencer |
| frame_in | input | 1 | Frame start, asynchronous |
| line_in | input | NUM_CH | Per-channel line clocks, asynchronous |
| ovr_start | input | 2 | Override for the start pulse output |
| ovr_true | input | 2*NUM_CH | Overrides for the true outputs, 2 bits per channel |
| ovr_comp | input | 2*NUM_CH | Overrides for the complementary outputs, 2 bits per channel |
| start_drv | output | 2 | Start pulse drive code |
| true_drv | output | 2*NUM_CH | True scan clock drive codes, channel i at bits 2i+1:2i |
| comp_drv | output | 2*NUM_CH | Complementary scan clock drive codes, same packing |
| share_en | output | NUM_CH | Per-channel charge-share enables |

## Verification
The bench builds the block with its defaults, NUM_CH = 3 and SYNC_STAGES = 2. With these values, three line clocks can be moved independently to show channel isolation, and the output latency comes to exactly three clock edges. One scenario samples on both sides of that edge. The stored state is exercised through double toggles, through edges that arrive while frame start is high, and through a disable and re-enable. That last sequence tells a cleared state apart from a retained one.

// File: rtl/scan_drv_pkg.sv
`timescale 1ns/1ps
package scan_drv_pkg;
  localparam logic [1:0] DRV_HIZ  = 2'b00;
  localparam logic [1:0] DRV_LOW  = 2'b01;
  localparam logic [1:0] DRV_HIGH = 2'b10;

  localparam logic [1:0] OVR_NONE = 2'b00;
  localparam logic [1:0] OVR_LOW  = 2'b01;
  localparam logic [1:0] OVR_HIZ  = 2'b10;

  function automatic logic [1:0] apply_ovr(input logic [1:0] drv, input logic [1:0] ovr);
    logic [1:0] r;
    case (ovr)
      OVR_LOW: r = DRV_LOW;
      OVR_HIZ: r = DRV_HIZ;
      default: r = drv;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/scan_sync.sv
`timescale 1ns/1ps
module scan_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scan_chan.sv
`timescale 1ns/1ps
module scan_chan
  import scan_drv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       frame_s,
  input  logic       line_s,
  input  logic [1:0] ovr_t,
  input  logic [1:0] ovr_c,
  output logic [1:0] true_q,
  output logic [1:0] comp_q,
  output logic       share_q
);
  logic       line_d;
  logic       tog, tog_n;
  logic       rise;
  logic [1:0] true_n, comp_n;
  logic       share_n;

  assign rise = line_s & ~line_d;

  always_comb begin
    tog_n = tog;
    if (!en)                  tog_n = 1'b0;
    else if (!frame_s && rise) tog_n = ~tog;
  end

  always_comb begin
    true_n  = DRV_LOW;
    comp_n  = DRV_LOW;
    share_n = 1'b0;
    if (en) begin
      if (frame_s) begin
        true_n = line_s ? DRV_HIGH : DRV_LOW;
        comp_n = line_s ? DRV_LOW  : DRV_HIGH;
      end else if (!line_s) begin
        true_n  = DRV_HIZ;
        comp_n  = DRV_HIZ;
        share_n = 1'b1;
      end else begin
        true_n = tog_n ? DRV_HIGH : DRV_LOW;
        comp_n = tog_n ? DRV_LOW  : DRV_HIGH;
      end
      true_n = apply_ovr(true_n, ovr_t);
      comp_n = apply_ovr(comp_n, ovr_c);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_d  <= 1'b0;
      tog     <= 1'b0;
      true_q  <= DRV_LOW;
      comp_q  <= DRV_LOW;
      share_q <= 1'b0;
    end else begin
      line_d  <= line_s;
      tog     <= tog_n;
      true_q  <= true_n;
      comp_q  <= comp_n;
      share_q <= share_n;
    end
  end

  // R1: the unused code never reaches an output
  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (true_q != 2'b11) && (comp_q != 2'b11));

  // R2: sharing never coincides with a driven high rail
  p_share_no_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    share_q |-> (true_q != DRV_HIGH) && (comp_q != DRV_HIGH));

  // R3: a qualified rising edge flips the stored state
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_s && line_s && !line_d) |=> (tog != $past(tog)));

  // R9: disabled means low rail, no sharing, cleared state
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (true_q == DRV_LOW) && (comp_q == DRV_LOW) && !share_q && !tog);
endmodule

// File: rtl/scan_start.sv
`timescale 1ns/1ps
module scan_start
  import scan_drv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       frame_s,
  input  logic       line0_s,
  input  logic [1:0] ovr,
  output logic [1:0] start_q
);
  logic [1:0] start_n;

  always_comb begin
    start_n = DRV_LOW;
    if (en) begin
      if (frame_s) start_n = line0_s ? DRV_HIZ : DRV_HIGH;
      else         start_n = DRV_LOW;
      start_n = apply_ovr(start_n, ovr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= DRV_LOW;
    else        start_q <= start_n;
  end

  // R7: frame start low keeps the start output on the low rail
  p_start_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_s && ovr == OVR_NONE) |=> (start_q == DRV_LOW));

  // R8: frame start high never yields the low rail without an override
  p_start_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_s && ovr == OVR_NONE) |=> (start_q != DRV_LOW));
endmodule

// File: rtl/scan_clk_ctrl.sv
`timescale 1ns/1ps
module scan_clk_ctrl
  import scan_drv_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  frame_in,
  input  logic [NUM_CH-1:0]     line_in,
  input  logic [1:0]            ovr_start,
  input  logic [2*NUM_CH-1:0]   ovr_true,
  input  logic [2*NUM_CH-1:0]   ovr_comp,
  output logic [1:0]            start_drv,
  output logic [2*NUM_CH-1:0]   true_drv,
  output logic [2*NUM_CH-1:0]   comp_drv,
  output logic [NUM_CH-1:0]     share_en
);
  localparam int SW = NUM_CH + 1;

  logic [1:0]    rst_pipe;
  logic          rst_i_n;
  logic [SW-1:0] sync_q;
  logic          frame_s;
  logic [NUM_CH-1:0] line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  scan_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     ({frame_in, line_in}),
    .q     (sync_q)
  );
  assign frame_s = sync_q[SW-1];
  assign line_s  = sync_q[NUM_CH-1:0];

  scan_start u_start (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .en      (en),
    .frame_s (frame_s),
    .line0_s (line_s[0]),
    .ovr     (ovr_start),
    .start_q (start_drv)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    scan_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .en      (en),
      .frame_s (frame_s),
      .line_s  (line_s[g]),
      .ovr_t   (ovr_true[2*g +: 2]),
      .ovr_c   (ovr_comp[2*g +: 2]),
      .true_q  (true_drv[2*g +: 2]),
      .comp_q  (comp_drv[2*g +: 2]),
      .share_q (share_en[g])
    );
  end
endmodule

// File: tb/scan_clk_ctrl_test.sv
`timescale 1ns/1ps
module scan_clk_ctrl_test;
  localparam int NCH = 3;
  localparam int LAT = 3;
  localparam logic [1:0] HZ = 2'b00, LO = 2'b01, HI = 2'b10;

  logic clk = 0;
  logic rst_n, en, frame_in;
  logic [NCH-1:0] line_in;
  logic [1:0] ovr_start;
  logic [2*NCH-1:0] ovr_true, ovr_comp;
  logic [1:0] start_drv;
  logic [2*NCH-1:0] true_drv, comp_drv;
  logic [NCH-1:0] share_en;

  int n_chk = 0, n_bad = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  scan_clk_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .frame_in(frame_in), .line_in(line_in),
    .ovr_start(ovr_start), .ovr_true(ovr_true), .ovr_comp(ovr_comp),
    .start_drv(start_drv), .true_drv(true_drv), .comp_drv(comp_drv), .share_en(share_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  task automatic settle();
    repeat (LAT) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] tc(int i); return true_drv[2*i +: 2]; endfunction
  function automatic logic [1:0] cc(int i); return comp_drv[2*i +: 2]; endfunction

  task automatic t_reset();
    rst_n = 0; en = 0; frame_in = 0; line_in = '0;
    ovr_start = 2'b00; ovr_true = '0; ovr_comp = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset true", {2'b0, true_drv}, {2'b0, {NCH{LO}}});
    chk("R1 reset comp", {2'b0, comp_drv}, {2'b0, {NCH{LO}}});
    chk("R1 reset start", {6'b0, start_drv}, {6'b0, LO});
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R1 released share", {5'b0, share_en}, 8'h0);
    chk("R1 released true", {2'b0, true_drv}, {2'b0, {NCH{LO}}});
  endtask

  task automatic t_float();
    en = 1;
    settle();
    chk("R2 true hiz", {2'b0, true_drv}, 8'h00);
    chk("R2 comp hiz", {2'b0, comp_drv}, 8'h00);
    chk("R2 share", {5'b0, share_en}, 8'h07);
    chk("R7 start low", {6'b0, start_drv}, {6'b0, LO});
  endtask

  task automatic t_toggle();
    line_in[0] = 1;
    repeat (LAT-1) @(posedge clk);
    @(negedge clk);
    chk("R11 not yet", {6'b0, tc(0)}, {6'b0, HZ});
    @(posedge clk); @(negedge clk);
    chk("R11 R3 true high", {6'b0, tc(0)}, {6'b0, HI});
    chk("R3 comp low", {6'b0, cc(0)}, {6'b0, LO});
    chk("R3 share off", {7'b0, share_en[0]}, 8'h0);
    chk("R12 ch1 untouched", {6'b0, tc(1)}, {6'b0, HZ});
    chk("R7 start with line0 high", {6'b0, start_drv}, {6'b0, LO});
    repeat (10) @(negedge clk);
    chk("R4 hold", {6'b0, tc(0)}, {6'b0, HI});
    line_in[0] = 0; settle();
    chk("R2 back to hiz", {6'b0, tc(0)}, {6'b0, HZ});
    line_in[0] = 1; settle();
    chk("R3 second toggle true", {6'b0, tc(0)}, {6'b0, LO});
    chk("R3 second toggle comp", {6'b0, cc(0)}, {6'b0, HI});
    line_in[0] = 0; settle();
  endtask

  task automatic t_frame();
    frame_in = 1; settle();
    chk("R5 true low", {6'b0, tc(0)}, {6'b0, LO});
    chk("R5 comp high", {6'b0, cc(0)}, {6'b0, HI});
    chk("R5 share off", {5'b0, share_en}, 8'h0);
    chk("R8 start high", {6'b0, start_drv}, {6'b0, HI});
    line_in[0] = 1; settle();
    chk("R6 true high", {6'b0, tc(0)}, {6'b0, HI});
    chk("R6 comp low", {6'b0, cc(0)}, {6'b0, LO});
    chk("R8 start hiz", {6'b0, start_drv}, {6'b0, HZ});
    frame_in = 0; settle();
    chk("R4 no toggle in frame", {6'b0, tc(0)}, {6'b0, LO});
    chk("R7 start low again", {6'b0, start_drv}, {6'b0, LO});
    line_in[0] = 0; settle();
  endtask

  task automatic t_override();
    ovr_true[1:0] = 2'b01; settle();
    chk("R10 force low", {6'b0, tc(0)}, {6'b0, LO});
    chk("R10 share kept", {7'b0, share_en[0]}, 8'h1);
    ovr_true[1:0] = 2'b11; frame_in = 1; ovr_comp[1:0] = 2'b10; settle();
    chk("R10 code 11 passes", {6'b0, tc(0)}, {6'b0, LO});
    chk("R10 force hiz", {6'b0, cc(0)}, {6'b0, HZ});
    ovr_start = 2'b01; settle();
    chk("R10 start forced low", {6'b0, start_drv}, {6'b0, LO});
    ovr_start = 2'b00; ovr_true = '0; ovr_comp = '0; frame_in = 0; settle();
  endtask

  task automatic t_disable();
    line_in[2] = 1; settle();
    chk("R3 ch2 high", {6'b0, tc(2)}, {6'b0, HI});
    chk("R12 ch0 still hiz", {6'b0, tc(0)}, {6'b0, HZ});
    line_in[2] = 0;
    ovr_true = {NCH{2'b10}}; ovr_start = 2'b10;
    en = 0; settle();
    chk("R9 true low", {2'b0, true_drv}, {2'b0, {NCH{LO}}});
    chk("R9 comp low", {2'b0, comp_drv}, {2'b0, {NCH{LO}}});
    chk("R9 start low", {6'b0, start_drv}, {6'b0, LO});
    chk("R9 share off", {5'b0, share_en}, 8'h0);
    ovr_true = '0; ovr_start = 2'b00;
    en = 1; settle();
    line_in[2] = 1; settle();
    chk("R9 state cleared", {6'b0, tc(2)}, {6'b0, HI});
  endtask

  initial begin
    t_reset();
    t_float();
    t_toggle();
    t_frame();
    t_override();
    t_disable();
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
    $finish;
  end
endmodule